// File: doc/BRIEF.md
# Paged Serial Flash Read Master

This block is the host side of a four-wire serial link to a paged flash device. A user request names one of three read-type commands: a direct page read, a read of the device's page buffer, or a copy of a page into that buffer. Each request also carries a page number, a starting byte offset and a byte count. The master builds the command frame for that request and shifts it out. It then clocks in the requested number of bytes and hands each byte to the user with a one-cycle strobe and the offset that byte came from.

The serial clock runs at a rate derived from the system clock by a divider parameter. Serial output is sampled on the rising serial clock edge, and new bits go out on the falling edge. Pages and the buffer hold 264 bytes, and the device wraps a long read back to offset 0. The master follows that wrap in the offsets it reports. After each frame, chip select is held high for a minimum recovery time before the next command may begin.

Top module: `paged_flash_reader`

## Requirements
- R1: Out of reset and whenever busy is low: chip select is high, the serial clock is low, and no byte strobe or done pulse is given.
- R2: Command code 0 (page read) sends 64 bits, most significant bit first: 0x52, six zero bits, the 9-bit page, the 9-bit offset, then 32 zero bits.
- R3: Command code 1 (buffer read) sends 40 bits, most significant bit first: 0x54, fifteen zero bits, the 9-bit offset, then 8 zero bits.
- R4: Command code 2 (page-to-buffer copy) sends 32 bits: 0x53, six zero bits, the 9-bit page, then nine zero bits. Chip select then rises with no data phase and no byte strobes.
- R5: For a read with count N > 0, exactly 8*N further rising serial edges follow the command bits. Each group of eight forms one byte, first bit as the most significant, sampled on the rising edge. Each byte is presented with a one-cycle strobe, and chip select rises after the last byte.
- R6: The reported offset of byte i is (start + i) mod 264, so the offset after 263 is 0. The start offset must be below 264.
- R7: The serial clock is low whenever chip select is high. Chip select falls at least one half serial period before the first rising serial edge.
- R8: Chip select stays high for at least two serial periods (four half periods) between commands. Busy stays high through that gap, and done pulses for one cycle when chip select rises.
- R9: A start request while busy is ignored, and a start with command code 3 is ignored.
- R10: A read (code 0 or 1) with count 0 sends only its command bits and gives no byte strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| cmd_i | input | 2 | Command code: 0 page read, 1 buffer read, 2 page-to-buffer copy |
| page_i | input | 9 | Page number |
| offs_i | input | 9 | Starting byte offset |
| count_i | input | 16 | Number of bytes to read |
| busy_o | output | 1 | Command in progress or recovery gap running |
| done_o | output | 1 | One-cycle pulse when the frame ends |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o |
| byte_offs_o | output | 9 | Page or buffer offset of byte_o |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
A wrong command-bit counter or a wrong shift register shows up as a header that does not match the expected bits, or a wrong count of serial edges. Either appears as soon as chip select rises on the first frame. A wrong byte counter or bit counter gives too many or too few strobes, or bytes misaligned by some bit positions; the first wrong byte already differs. A bad wrap in the offset tracker is only visible once a read crosses offset 263, so reads that start near the end of the page and the buffer are run. The recovery-gap counter is checked by the chip-select high time between back-to-back commands.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

   localparam int OPC_W = 8;
   localparam logic [OPC_W-1:0] OPC_PAGE_RD = 8'h52;
   localparam logic [OPC_W-1:0] OPC_BUF_RD  = 8'h54;
   localparam logic [OPC_W-1:0] OPC_COPY    = 8'h53;

   localparam logic [1:0] CMD_PAGE_RD = 2'd0;
   localparam logic [1:0] CMD_BUF_RD  = 2'd1;
   localparam logic [1:0] CMD_COPY    = 2'd2;
   localparam logic [1:0] CMD_NONE    = 2'd3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_DATA = 2'd2,
      ST_GAP  = 2'd3
   } pfr_state_e;

endpackage

// File: rtl/pfr_clkdiv.sv
module pfr_clkdiv #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   if (DIV < 1) begin : g_bad_div
      $error("pfr_clkdiv: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick = run;
   end else begin : g_count
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (!run || cnt == CW'(DIV - 1)) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end

      assign tick = run && (cnt == CW'(DIV - 1));
   end

endmodule

// File: rtl/pfr_frame.sv
module pfr_frame
   import pfr_pkg::*;
#(
   parameter int PAGE_W   = 9,
   parameter int OFFS_W   = 9,
   parameter int RSV_W    = 6,
   parameter int PR_DUMMY = 32,
   parameter int BR_PRE   = 15,
   parameter int BR_POST  = 8,
   localparam int HDR_W   = OPC_W + RSV_W + PAGE_W + OFFS_W + PR_DUMMY,
   localparam int LEN_W   = $clog2(HDR_W + 1)
) (
   input  logic [1:0]        cmd,
   input  logic [PAGE_W-1:0] page,
   input  logic [OFFS_W-1:0] offs,
   output logic [HDR_W-1:0]  hdr,
   output logic [LEN_W-1:0]  hdr_len,
   output logic              has_data
);

   localparam int BR_LEN = OPC_W + BR_PRE + OFFS_W + BR_POST;
   localparam int CP_LEN = OPC_W + RSV_W + PAGE_W + OFFS_W;

   if (BR_LEN > HDR_W) begin : g_bad_len
      $error("pfr_frame: buffer read frame longer than page read frame");
   end

   always_comb begin
      unique case (cmd)
         CMD_PAGE_RD: begin
            hdr      = {OPC_PAGE_RD, {RSV_W{1'b0}}, page, offs, {PR_DUMMY{1'b0}}};
            hdr_len  = LEN_W'(HDR_W);
            has_data = 1'b1;
         end
         CMD_BUF_RD: begin
            hdr      = {OPC_BUF_RD, {BR_PRE{1'b0}}, offs,
                        {(BR_POST + HDR_W - BR_LEN){1'b0}}};
            hdr_len  = LEN_W'(BR_LEN);
            has_data = 1'b1;
         end
         default: begin
            hdr      = {OPC_COPY, {RSV_W{1'b0}}, page, {(OFFS_W + PR_DUMMY){1'b0}}};
            hdr_len  = LEN_W'(CP_LEN);
            has_data = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/pfr_rx.sv
module pfr_rx #(
   parameter int OFFS_W     = 9,
   parameter int PAGE_BYTES = 264
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [OFFS_W-1:0] start_offs,
   input  logic              sample,
   input  logic              miso,
   output logic              byte_end,
   output logic [7:0]        byte_o,
   output logic              valid_o,
   output logic [OFFS_W-1:0] offs_o
);

   localparam logic [OFFS_W-1:0] LAST = OFFS_W'(PAGE_BYTES - 1);

   logic [6:0]        sr;
   logic [2:0]        bcnt;
   logic [OFFS_W-1:0] cur;

   assign byte_end = sample && (bcnt == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr      <= '0;
         bcnt    <= '0;
         cur     <= '0;
         byte_o  <= '0;
         valid_o <= 1'b0;
         offs_o  <= '0;
      end else begin
         valid_o <= 1'b0;
         if (load) begin
            bcnt <= '0;
            cur  <= start_offs;
         end else if (sample) begin
            sr   <= {sr[5:0], miso};
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
               byte_o  <= {sr, miso};
               valid_o <= 1'b1;
               offs_o  <= cur;
               cur     <= (cur >= LAST) ? '0 : cur + OFFS_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/paged_flash_reader.sv
module paged_flash_reader
   import pfr_pkg::*;
#(
   parameter int CLK_DIV    = 2,
   parameter int PAGE_W     = 9,
   parameter int OFFS_W     = 9,
   parameter int RSV_W      = 6,
   parameter int PR_DUMMY   = 32,
   parameter int BR_PRE     = 15,
   parameter int BR_POST    = 8,
   parameter int PAGE_BYTES = 264,
   parameter int CNT_W      = 16,
   parameter int GAP_HALVES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        cmd_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [OFFS_W-1:0] offs_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [7:0]        byte_o,
   output logic              byte_valid_o,
   output logic [OFFS_W-1:0] byte_offs_o,
   output logic              cs_n_o,
   output logic              sclk_o,
   output logic              mosi_o,
   input  logic              miso_i
);

   localparam int HDR_W = OPC_W + RSV_W + PAGE_W + OFFS_W + PR_DUMMY;
   localparam int LEN_W = $clog2(HDR_W + 1);
   localparam int GC_W  = $clog2(GAP_HALVES);

   if (PAGE_BYTES > (1 << OFFS_W) || PAGE_BYTES < 2) begin : g_bad_page
      $error("paged_flash_reader: PAGE_BYTES does not fit OFFS_W");
   end
   if (GAP_HALVES < 2) begin : g_bad_gap
      $error("paged_flash_reader: GAP_HALVES must be at least 2");
   end

   pfr_state_e        st;
   logic [HDR_W-1:0]  sh;
   logic [LEN_W-1:0]  hdr_left;
   logic [CNT_W-1:0]  bytes_left;
   logic              want_data;
   logic [GC_W-1:0]   gap_cnt;
   logic              cs_n, sclk, done;

   logic [HDR_W-1:0]  f_hdr;
   logic [LEN_W-1:0]  f_len;
   logic              f_data;
   logic              tick, accept, sample, byte_end;

   assign accept = (st == ST_IDLE) && start_i && (cmd_i != CMD_NONE);
   assign sample = (st == ST_DATA) && tick && !sclk;

   pfr_clkdiv #(.DIV(CLK_DIV)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (st != ST_IDLE),
      .tick (tick)
   );

   pfr_frame #(
      .PAGE_W  (PAGE_W),
      .OFFS_W  (OFFS_W),
      .RSV_W   (RSV_W),
      .PR_DUMMY(PR_DUMMY),
      .BR_PRE  (BR_PRE),
      .BR_POST (BR_POST)
   ) u_frame (
      .cmd     (cmd_i),
      .page    (page_i),
      .offs    (offs_i),
      .hdr     (f_hdr),
      .hdr_len (f_len),
      .has_data(f_data)
   );

   pfr_rx #(.OFFS_W(OFFS_W), .PAGE_BYTES(PAGE_BYTES)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .start_offs(offs_i),
      .sample    (sample),
      .miso      (miso_i),
      .byte_end  (byte_end),
      .byte_o    (byte_o),
      .valid_o   (byte_valid_o),
      .offs_o    (byte_offs_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         sh         <= '0;
         hdr_left   <= '0;
         bytes_left <= '0;
         want_data  <= 1'b0;
         gap_cnt    <= '0;
         cs_n       <= 1'b1;
         sclk       <= 1'b0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  sh         <= f_hdr;
                  hdr_left   <= f_len;
                  bytes_left <= count_i;
                  want_data  <= f_data && (count_i != '0);
                  cs_n       <= 1'b0;
                  st         <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk <= 1'b1;
                  end else begin
                     sclk     <= 1'b0;
                     sh       <= {sh[HDR_W-2:0], 1'b0};
                     hdr_left <= hdr_left - LEN_W'(1);
                     if (hdr_left == LEN_W'(1)) begin
                        if (want_data) begin
                           st <= ST_DATA;
                        end else begin
                           cs_n    <= 1'b1;
                           done    <= 1'b1;
                           gap_cnt <= '0;
                           st      <= ST_GAP;
                        end
                     end
                  end
               end
            end
            ST_DATA: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk <= 1'b1;
                     if (byte_end) bytes_left <= bytes_left - CNT_W'(1);
                  end else begin
                     sclk <= 1'b0;
                     if (bytes_left == '0) begin
                        cs_n    <= 1'b1;
                        done    <= 1'b1;
                        gap_cnt <= '0;
                        st      <= ST_GAP;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_cnt == GC_W'(GAP_HALVES - 1)) st <= ST_IDLE;
                  else gap_cnt <= gap_cnt + GC_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (st != ST_IDLE);
   assign done_o = done;
   assign cs_n_o = cs_n;
   assign sclk_o = sclk;
   assign mosi_o = (st == ST_HDR) && sh[HDR_W-1];

endmodule

// File: rtl/pfr_chk.sv
module pfr_chk #(
   parameter int CLK_DIV    = 2,
   parameter int GAP_HALVES = 4,
   parameter int PAGE_BYTES = 264,
   parameter int OFFS_W     = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              cs_n,
   input logic              sclk,
   input logic              valid,
   input logic [OFFS_W-1:0] offs
);

   localparam int GAP_MIN = GAP_HALVES * CLK_DIV;
   localparam int HC_W    = $clog2(GAP_MIN + 2);

   logic [HC_W-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_cnt <= HC_W'(GAP_MIN);
      else if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt < HC_W'(GAP_MIN)) hi_cnt <= hi_cnt + HC_W'(1);
   end

   // R1
   idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   // R7
   sclk_low_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R7
   sclk_moves_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk) |-> busy);

   // R5
   strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R5
   strobe_inside_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> busy);

   // R6
   offs_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (offs < OFFS_W'(PAGE_BYTES)));

   // R8
   deselect_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (hi_cnt >= HC_W'(GAP_MIN)));

endmodule

bind paged_flash_reader pfr_chk #(
   .CLK_DIV   (CLK_DIV),
   .GAP_HALVES(GAP_HALVES),
   .PAGE_BYTES(PAGE_BYTES),
   .OFFS_W    (OFFS_W)
) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .busy (busy_o),
   .cs_n (cs_n_o),
   .sclk (sclk_o),
   .valid(byte_valid_o),
   .offs (byte_offs_o)
);

// File: tb/paged_flash_reader_tb.sv
module paged_flash_reader_tb;

   localparam int DIV    = 2;
   localparam int PBYTES = 264;
   localparam logic [8:0] BUF_ID = 9'h1AB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  cmd_i = '0;
   logic [8:0]  page_i = '0;
   logic [8:0]  offs_i = '0;
   logic [15:0] count_i = '0;
   logic        busy_o, done_o, byte_valid_o, cs_n_o, sclk_o, mosi_o;
   logic [7:0]  byte_o;
   logic [8:0]  byte_offs_o;
   logic        miso = 1'b0;

   int checks = 0;
   int errors = 0;
   bit ended  = 0;

   always #5 clk = ~clk;

   paged_flash_reader #(.CLK_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
      .page_i(page_i), .offs_i(offs_i), .count_i(count_i),
      .busy_o(busy_o), .done_o(done_o), .byte_o(byte_o),
      .byte_valid_o(byte_valid_o), .byte_offs_o(byte_offs_o),
      .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso)
   );

   function automatic logic [7:0] mb(input logic [8:0] p, input int o);
      return 8'((int'(p) * 31 + o * 7 + 3) & 255);
   endfunction

   // flash model
   logic [63:0] rx_hdr = '0;
   int rise_cnt = 0;
   int frames   = 0;

   always @(negedge cs_n_o) begin
      rise_cnt = 0;
      rx_hdr   = '0;
      frames++;
   end

   always @(posedge sclk_o) if (!cs_n_o) begin
      if (rise_cnt < 64) rx_hdr[63 - rise_cnt] = mosi_o;
      rise_cnt++;
   end

   always @(negedge sclk_o) if (!cs_n_o) begin
      int hl, k;
      logic [8:0] pg;
      logic [7:0] bv;
      hl = (rx_hdr[63:56] == 8'h52) ? 64 : (rx_hdr[63:56] == 8'h54) ? 40 : 100000;
      if (rise_cnt >= hl) begin
         k  = rise_cnt - hl;
         pg = (rx_hdr[63:56] == 8'h54) ? BUF_ID : rx_hdr[49:41];
         bv = mb(pg, (int'(rx_hdr[40:32]) + k / 8) % PBYTES);
         miso = bv[7 - (k % 8)];
      end else begin
         miso = 1'b0;
      end
   end

   // output monitors
   logic [7:0] got_byte [0:511];
   int         got_offs [0:511];
   int nb = 0;
   int done_cnt = 0;
   int idle_viol = 0;
   int hi_run = 0;
   int last_gap = 0;
   logic prev_cs = 1'b1;

   always @(negedge clk) begin
      if (byte_valid_o) begin
         if (nb < 512) begin
            got_byte[nb] = byte_o;
            got_offs[nb] = int'(byte_offs_o);
         end
         nb++;
      end
      if (done_o) done_cnt++;
      if (cs_n_o && sclk_o) idle_viol++;
      if (cs_n_o) hi_run++;
      else if (prev_cs) begin
         last_gap = hi_run;
         hi_run   = 0;
      end
      prev_cs = cs_n_o;
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] c, input logic [8:0] p,
                        input logic [8:0] o, input int n);
      @(negedge clk);
      nb      = 0;
      cmd_i   = c;
      page_i  = p;
      offs_i  = o;
      count_i = n[15:0];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_idle;
      do @(negedge clk); while (busy_o);
   endtask

   task automatic verify(input logic [1:0] c, input logic [8:0] p,
                         input logic [8:0] o, input int n, input int done_before);
      int hl, bc;
      logic [63:0] exp;
      string ft;
      case (c)
         2'd0: begin hl = 64; exp = {8'h52, 6'b0, p, o, 32'b0}; ft = "R2"; end
         2'd1: begin hl = 40; exp = {8'h54, 15'b0, o, 8'b0, 24'b0}; ft = "R3"; end
         default: begin hl = 32; exp = {8'h53, 6'b0, p, 9'b0, 32'b0}; ft = "R4"; end
      endcase
      bc = (c == 2'd2 || n == 0) ? 0 : n;
      check((rx_hdr >> (64 - hl)) == (exp >> (64 - hl)), ft, "command bits",
            int'(rx_hdr[63:32]), int'(exp[63:32]));
      check(rise_cnt == hl + 8 * bc, "R5", "serial edge count", rise_cnt, hl + 8 * bc);
      check(nb == bc, "R5", "byte strobes", nb, bc);
      check(done_cnt == done_before + 1, "R8", "done pulses", done_cnt, done_before + 1);
      for (int i = 0; i < bc && i < 512; i++) begin
         int eo;
         eo = (int'(o) + i) % PBYTES;
         check(got_offs[i] == eo, "R6", "byte offset", got_offs[i], eo);
         check(got_byte[i] == mb((c == 2'd1) ? BUF_ID : p, eo), "R5", "byte value",
               int'(got_byte[i]), int'(mb((c == 2'd1) ? BUF_ID : p, eo)));
      end
   endtask

   task automatic run_cmd(input logic [1:0] c, input logic [8:0] p,
                          input logic [8:0] o, input int n);
      int d0;
      d0 = done_cnt;
      issue(c, p, o, n);
      wait_idle();
      verify(c, p, o, n, d0);
   endtask

   task automatic t_reset;
      // R1
      check(cs_n_o == 1'b1, "R1", "cs_n after reset", int'(cs_n_o), 1);
      check(sclk_o == 1'b0, "R1", "sclk after reset", int'(sclk_o), 0);
      check(busy_o == 1'b0, "R1", "busy after reset", int'(busy_o), 0);
      check(byte_valid_o == 1'b0 && done_o == 1'b0, "R1", "strobes after reset",
            int'(byte_valid_o) + int'(done_o), 0);
   endtask

   task automatic t_page_read;
      run_cmd(2'd0, 9'd37, 9'd5, 4);
      run_cmd(2'd0, 9'h1FF, 9'd0, 3);
   endtask

   task automatic t_page_wrap;   // R6 wrap inside a page
      run_cmd(2'd0, 9'd300, 9'd260, 10);
   endtask

   task automatic t_buf_read;
      run_cmd(2'd1, 9'd0, 9'd100, 3);
      run_cmd(2'd1, 9'd0, 9'd262, 270);
   endtask

   task automatic t_copy;       // R4
      run_cmd(2'd2, 9'd123, 9'd77, 5);
   endtask

   task automatic t_zero_count; // R10
      int f0;
      f0 = frames;
      run_cmd(2'd0, 9'd9, 9'd11, 0);
      run_cmd(2'd1, 9'd0, 9'd44, 0);
      check(frames == f0 + 2, "R10", "frames for zero-count reads", frames, f0 + 2);
   endtask

   task automatic t_busy_ignore; // R9
      int f0, d0;
      f0 = frames;
      d0 = done_cnt;
      issue(2'd0, 9'd55, 9'd20, 2);
      repeat (40) @(negedge clk);
      cmd_i   = 2'd1;
      offs_i  = 9'd3;
      page_i  = 9'd1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_idle();
      repeat (40) @(negedge clk);
      check(frames == f0 + 1, "R9", "frames after start while busy", frames, f0 + 1);
      verify(2'd0, 9'd55, 9'd20, 2, d0);
      f0 = frames;
      issue(2'd3, 9'd1, 9'd1, 4);
      repeat (40) @(negedge clk);
      check(frames == f0, "R9", "frames after code 3", frames, f0);
      check(busy_o == 1'b0, "R9", "busy after code 3", int'(busy_o), 0);
   endtask

   task automatic t_gap;        // R8 back-to-back commands
      issue(2'd2, 9'd4, 9'd0, 0);
      wait_idle();
      issue(2'd2, 9'd5, 9'd0, 0);
      wait_idle();
      check(last_gap >= 4 * DIV, "R8", "cs_n high cycles between commands",
            last_gap, 4 * DIV);
      check(rx_hdr[49:41] == 9'd5, "R8", "second command page", int'(rx_hdr[49:41]), 5);
   endtask

   task automatic t_idle_clock; // R7
      check(idle_viol == 0, "R7", "sclk high while deselected", idle_viol, 0);
   endtask

   task automatic summary;
      if (!ended) begin
         ended = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_page_read();
      t_page_wrap();
      t_buf_read();
      t_copy();
      t_zero_count();
      t_busy_ignore();
      t_gap();
      t_idle_clock();
      summary();
   end

endmodule